// File: doc/BRIEF.md
# UART Receive Character Queue with Request-to-Send Pacing

This block sits between a serial receiver's shift register and the host read port of a UART. Each completed character that the receiver presents is stored in a first-in first-out queue. The host pops the oldest character through a read strobe. A status output shows when data is waiting. A receive interrupt is asserted while the number of stored characters is at or above a threshold, and the threshold is picked by a 2-bit code in the control word.

A control write turns the queue on or off, empties the receive queue, and sends a one-cycle clear pulse to the transmit side. With the queue turned off, the block acts as a single holding register. A separate modem-control write can enable automatic request-to-send pacing. In that mode the RTS line rises when a character arrives, which asks the far end to pause, and falls again when the host reads a character.

Top module: `uart_rx_fifo_rts`

## Requirements
- R1: After reset, data_ready, rx_irq, overrun, rts and tx_fifo_clr are 0, and ctrl_rdata reads 0x00.
- R2: Characters are read in arrival order. rd_data always shows the oldest stored character, and data_ready (status bit 0) is 1 exactly when at least one character is stored.
- R3: With the queue enabled (control bit 0 = 1), up to DEPTH (16) characters are held. A character that arrives when the queue is full, with no read in the same cycle, is discarded, the stored characters are left unchanged, and overrun is set from the next cycle on.
- R4: With control bit 0 = 0, only one character is held. A second arrival before a read is discarded and sets overrun, and the receive interrupt threshold is 1 whatever the trigger code.
- R5: Control bits 7:6 select the interrupt threshold: code 0 means 1 character, 1 means 4, 2 means 8 and 3 means 14. rx_irq is 1 exactly when the stored count is at or above the selected threshold.
- R6: rx_irq is taken straight from the stored count with no extra register. It falls in the same cycle that a read brings the count below the threshold.
- R7: Writing control bit 1 = 1 empties the receive queue and clears overrun, and the effect is visible in the next cycle. Bits 1 and 2 always read back as 0 in ctrl_rdata. The other bits read back as written: bit 0 and bits 7:6, with all remaining bits 0.
- R8: Writing control bit 2 = 1 makes tx_fifo_clr high for exactly the next cycle, and the receive contents are not affected.
- R9: With modem-control bit 6 = 1, rts goes high in the cycle after any character arrives. It goes low in the cycle after a host read that comes with no arrival. When an arrival and a read fall in the same cycle, rts goes high.
- R10: With modem-control bit 6 = 0, rts stays 0 whatever arrives or is read.
- R11: A read strobe while the queue is empty is ignored: data_ready stays 0 and the next character that arrives is returned correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | One-cycle strobe: a completed character is on rx_data |
| rx_data | input | DW | Character from the receiver shift register |
| ctrl_we | input | 1 | Control-word write strobe |
| ctrl_wdata | input | 8 | Control word: bit 0 enable, bit 1 receive clear, bit 2 transmit clear, bits 7:6 trigger code |
| ctrl_rdata | output | 8 | Control word read-back, with bits 1 and 2 always 0 |
| mcr_we | input | 1 | Modem-control write strobe |
| mcr_wdata | input | 8 | Modem-control word: bit 6 enables automatic RTS |
| rd_en | input | 1 | Host read strobe: pops the oldest character |
| rd_data | output | DW | Oldest stored character |
| data_ready | output | 1 | At least one character is stored |
| rx_irq | output | 1 | Stored count is at or above the threshold |
| overrun | output | 1 | Sticky flag: a character was discarded |
| rts | output | 1 | Request-to-send pacing output |
| tx_fifo_clr | output | 1 | One-cycle clear pulse for the transmit queue |

## Verification
The RTS properties assume that no modem-control write lands in the same cycle as the arrival or read they reason about. The pulse property assumes that the transmit clear bit is not written in two consecutive cycles. The bench keeps to both assumptions by issuing every control and modem-control write as a separate one-cycle strobe, with no data traffic in that cycle. It also raises rx_valid and rd_en only as single-cycle strobes driven on the falling edge.

// File: rtl/uart_rx_fifo_rts.sv
module uart_rx_fifo_rts #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          ctrl_we,
  input  logic [7:0]    ctrl_wdata,
  output logic [7:0]    ctrl_rdata,
  input  logic          mcr_we,
  input  logic [7:0]    mcr_wdata,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          data_ready,
  output logic          rx_irq,
  output logic          overrun,
  output logic          rts,
  output logic          tx_fifo_clr
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count, cap, level, thresh;
  logic          q_en, auto_rts, rts_q, ovr_q, txclr_q;
  logic [1:0]    trig;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  wire rx_clr = ctrl_we & ctrl_wdata[1];
  wire empty  = (count == '0);
  wire full   = (count >= cap);
  wire pop    = rd_en & ~empty & ~rx_clr;
  wire push   = rx_valid & ~rx_clr & (~full | pop);
  wire drop   = rx_valid & ~rx_clr & full & ~pop;

  always_comb begin
    case (trig)
      2'd0:    level = CW'(1);
      2'd1:    level = CW'(4);
      2'd2:    level = CW'(8);
      default: level = CW'(14);
    endcase
  end

  assign cap    = q_en ? CW'(DEPTH) : CW'(1);
  assign thresh = q_en ? level : CW'(1);

  assign ctrl_rdata  = {trig, 5'b0, q_en};
  assign rd_data     = mem[rd_ptr];
  assign data_ready  = ~empty;
  assign rx_irq      = (count >= thresh);
  assign overrun     = ovr_q;
  assign rts         = rts_q & auto_rts;
  assign tx_fifo_clr = txclr_q;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= rx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (rx_clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= step(wr_ptr);
      if (pop)  rd_ptr <= step(rd_ptr);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_en     <= 1'b0;
      trig     <= 2'd0;
      txclr_q  <= 1'b0;
      ovr_q    <= 1'b0;
      auto_rts <= 1'b0;
      rts_q    <= 1'b0;
    end else begin
      txclr_q <= ctrl_we & ctrl_wdata[2];
      if (ctrl_we) begin
        q_en <= ctrl_wdata[0];
        trig <= ctrl_wdata[7:6];
      end
      if (rx_clr)    ovr_q <= 1'b0;
      else if (drop) ovr_q <= 1'b1;
      if (mcr_we) auto_rts <= mcr_wdata[6];
      if (!auto_rts)     rts_q <= 1'b0;
      else if (rx_valid) rts_q <= 1'b1;
      else if (pop)      rts_q <= 1'b0;
    end
  end

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  assert_drop_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && full && !rd_en && !ctrl_we) |=> overrun);
  assert_rx_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && ctrl_wdata[1]) |=> (!data_ready && !overrun));
  assert_tx_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_fifo_clr) |=> !tx_fifo_clr);
  assert_irq_needs_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> data_ready);
  assert_rts_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rts && rx_valid && !mcr_we) |=> rts);
  assert_rts_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rts && data_ready && rd_en && !rx_valid && !mcr_we && !ctrl_we) |=> !rts);
endmodule

// File: tb/tb_uart_rx_fifo_rts.sv
module tb_uart_rx_fifo_rts;
  logic clk = 0, rst_n = 0;
  logic rx_valid = 0, ctrl_we = 0, mcr_we = 0, rd_en = 0;
  logic [7:0] rx_data = 0, ctrl_wdata = 0, mcr_wdata = 0;
  logic [7:0] ctrl_rdata, rd_data;
  logic data_ready, rx_irq, overrun, rts, tx_fifo_clr;
  int checks = 0, failures = 0;
  logic [7:0] exp_q[$];

  always #2 clk = ~clk;

  uart_rx_fifo_rts dut (.clk, .rst_n, .rx_valid, .rx_data, .ctrl_we, .ctrl_wdata,
    .ctrl_rdata, .mcr_we, .mcr_wdata, .rd_en, .rd_data, .data_ready, .rx_irq,
    .overrun, .rts, .tx_fifo_clr);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b, input bit accept);
    rx_valid = 1; rx_data = b;
    @(negedge clk);
    rx_valid = 0;
    if (accept) exp_q.push_back(b);
  endtask

  task automatic pop(input string req);
    logic [7:0] e;
    e = exp_q.pop_front();
    chk(rd_data == e, req, rd_data, e);
    rd_en = 1;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic wctrl(input logic [7:0] v);
    ctrl_we = 1; ctrl_wdata = v;
    @(negedge clk);
    ctrl_we = 0;
  endtask

  task automatic wmcr(input logic [7:0] v);
    mcr_we = 1; mcr_wdata = v;
    @(negedge clk);
    mcr_we = 0;
  endtask

  initial begin
    #(4 * 200000);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state
    chk({data_ready, rx_irq, overrun, rts, tx_fifo_clr} == 0, "R1 outputs", {data_ready, rx_irq, overrun, rts, tx_fifo_clr}, 0);
    chk(ctrl_rdata == 0, "R1 ctrl", ctrl_rdata, 0);
    rst_n = 1;
    @(negedge clk);
    wctrl(8'h01);
    chk(ctrl_rdata == 8'h01, "R7 readback", ctrl_rdata, 8'h01);
    // R11 read on empty
    rd_en = 1; @(negedge clk); rd_en = 0;
    chk(!data_ready, "R11 empty read", data_ready, 0);
    push(8'hA5, 1);
    chk(data_ready, "R2 data_ready", data_ready, 1);
    pop("R11 after empty read");
    chk(!data_ready, "R2 empty again", data_ready, 0);
    // R2 ordering
    push(8'h11, 1); push(8'h22, 1); push(8'h33, 1);
    pop("R2 order"); pop("R2 order"); pop("R2 order");
    // R5/R6 trigger code 1
    wctrl(8'h41);
    for (int i = 0; i < 3; i++) push(8'h40 + 8'(i), 1);
    chk(!rx_irq, "R5 code1 below", rx_irq, 0);
    push(8'h43, 1);
    chk(rx_irq, "R5 code1 at 4", rx_irq, 1);
    pop("R6 data");
    chk(!rx_irq, "R6 irq drops on read", rx_irq, 0);
    while (exp_q.size() > 0) pop("R2 drain");
    // code 2 then 3, fill and overflow
    wctrl(8'h81);
    for (int i = 0; i < 7; i++) push(8'h80 + 8'(i), 1);
    chk(!rx_irq, "R5 code2 at 7", rx_irq, 0);
    push(8'h87, 1);
    chk(rx_irq, "R5 code2 at 8", rx_irq, 1);
    wctrl(8'hC1);
    chk(!rx_irq, "R5 code3 at 8", rx_irq, 0);
    for (int i = 8; i < 13; i++) push(8'h80 + 8'(i), 1);
    chk(!rx_irq, "R5 code3 at 13", rx_irq, 0);
    push(8'h8D, 1);
    chk(rx_irq, "R5 code3 at 14", rx_irq, 1);
    push(8'h8E, 1); push(8'h8F, 1);
    chk(!overrun, "R3 no overrun at 16", overrun, 0);
    push(8'hEE, 0);
    chk(overrun, "R3 overrun", overrun, 1);
    for (int i = 0; i < 16; i++) pop("R3 contents kept");
    chk(!data_ready, "R3 drained", data_ready, 0);
    // R7 receive clear
    push(8'h01, 1); push(8'h02, 1);
    wctrl(8'hC3);
    exp_q.delete();
    chk(!data_ready && !overrun, "R7 cleared", {data_ready, overrun}, 0);
    chk(ctrl_rdata == 8'hC1, "R7 bit1 reads 0", ctrl_rdata, 8'hC1);
    // R8 transmit clear
    push(8'h5A, 1);
    wctrl(8'hC5);
    chk(tx_fifo_clr, "R8 pulse high", tx_fifo_clr, 1);
    chk(ctrl_rdata == 8'hC1, "R7 bit2 reads 0", ctrl_rdata, 8'hC1);
    @(negedge clk);
    chk(!tx_fifo_clr, "R8 pulse one cycle", tx_fifo_clr, 0);
    chk(data_ready, "R8 rx kept", data_ready, 1);
    pop("R8 rx data");
    // R4 disabled mode
    wctrl(8'hC0);
    push(8'h61, 1);
    chk(rx_irq, "R4 threshold 1", rx_irq, 1);
    push(8'h62, 0);
    chk(overrun, "R4 overrun", overrun, 1);
    pop("R4 first kept");
    chk(!data_ready, "R4 single entry", data_ready, 0);
    wctrl(8'h03);
    // R9 auto RTS
    wmcr(8'h40);
    chk(!rts, "R9 idle", rts, 0);
    push(8'h71, 1);
    chk(rts, "R9 rise on arrival", rts, 1);
    pop("R9 data");
    chk(!rts, "R9 fall on read", rts, 0);
    push(8'h72, 1);
    rx_valid = 1; rx_data = 8'h73; rd_en = 1;
    chk(rd_data == 8'h72, "R9 data", rd_data, 8'h72);
    void'(exp_q.pop_front());
    @(negedge clk);
    rx_valid = 0; rd_en = 0; exp_q.push_back(8'h73);
    chk(rts, "R9 both same cycle", rts, 1);
    pop("R9 data2");
    // R10 auto RTS off
    wmcr(8'h00);
    push(8'h74, 1);
    chk(!rts, "R10 rts stays low", rts, 0);
    pop("R10 data");
    chk(!rts, "R10 after read", rts, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule